// File: doc/BRIEF.md
# Stride-Detecting Stream Prefetcher

This block sits beside a core's data cache and watches the demand load addresses the core issues. It learns the constant distance (stride) between consecutive addresses. Once the same stride has been seen twice in a row, the block requests the cache line four strides ahead of the current access from the next cache level. Until a stride is confirmed, it asks for the line right after the one just touched, so that blocks act as if they were twice their size.

Every request is a 64-byte-aligned line address. A request is dropped when it would leave the 4 KB page of the access that caused it, when it falls in the very line being accessed, or when it repeats the line most recently issued. Strides may be negative. The request port uses a valid/ready handshake. A stalled request stays stable until a newer access produces a different line, and that newer line then replaces it. The request it replaces is discarded and is not queued.

Top module: `stride_prefetcher`

## Requirements
- R1: A synchronous active-high reset clears the address history, stride, confidence and the record of the last issued line. `pf_valid_o` is 0 in the first cycle after reset, and the first access after reset is handled as one with no history.
- R2: An access with no confirmed stride yields, in the cycle after the access, a request for the next line: the access address with its low 6 bits cleared, plus 64.
- R3: A stride is confirmed when two consecutive address deltas are equal and non-zero. A confirmed access yields, in the next cycle, a request for (address + 4 × stride) with its low 6 bits cleared.
- R4: A delta that differs from the stored stride, zero included, clears confirmation and becomes the new candidate stride. That access therefore gets a next-line request.
- R5: `pf_addr_o` always has bits [5:0] equal to 0 while `pf_valid_o` is 1.
- R6: No request is made when the target's bits [31:12] differ from those of the triggering access. This applies to both upward and downward strides.
- R7: No request is made when the target lies in the same 64-byte line as the triggering access.
- R8: No request is made when the target line equals the line most recently placed on the port.
- R9: Negative strides are learned and used through two's-complement delta arithmetic.
- R10: While `pf_valid_o` is 1 and `pf_ready_i` is 0, `pf_addr_o` holds steady. The only exception is a newer access with a different, unsuppressed target, which replaces it in the next cycle.
- R11: After a handshake (`pf_valid_o` and `pf_ready_i` both 1), `pf_valid_o` falls in the next cycle unless a new request is produced in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid_i | input | 1 | A demand access is presented |
| acc_addr_i | input | 32 | Byte address of the demand access |
| pf_valid_o | output | 1 | A prefetch request is pending |
| pf_ready_i | input | 1 | Next level accepts the request |
| pf_addr_o | output | 32 | Line-aligned prefetch address |

## Verification
Two things can fall in the same cycle: the port completing a handshake and a new access producing a fresh target. The bench provokes this by raising ready in the very cycle that a confirmed-stream access arrives while a stalled request is pending. The port must then show the new target with valid still high, not a bubble. The second clash is between a stall and a replacement. Accesses arrive while ready is low, and the bench checks that the held address changes only when the new target differs and passes the filters, and that it stays put during idle cycles.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

    // Outcome of filtering one candidate target
    typedef enum logic [1:0] {
        VERDICT_ISSUE    = 2'd0,
        VERDICT_OFF_PAGE = 2'd1,
        VERDICT_OWN_LINE = 2'd2,
        VERDICT_REPEAT   = 2'd3
    } pf_verdict_e;

endpackage

// File: rtl/stride_learn.sv
// Combinational stride learner: compares the new delta with the stored stride.
module stride_learn #(
    parameter int ADDR_W = 32
) (
    input  logic              have_hist_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              conf_i,
    output logic [ADDR_W-1:0] stride_o,
    output logic              conf_o
);
    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta    = cur_addr_i - last_addr_i;   // two's complement, R9
        stride_o = stride_i;
        conf_o   = conf_i;
        if (have_hist_i) begin
            if ((delta != '0) && (delta == stride_i)) begin
                conf_o = 1'b1;                 // R3
            end else begin
                conf_o   = 1'b0;               // R4
                stride_o = delta;
            end
        end
    end
endmodule

// File: rtl/pf_target_gen.sv
// Combinational target computation and filtering.
module pf_target_gen
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int LOOKAHEAD  = 4
) (
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic              conf_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              issued_valid_i,
    input  logic [ADDR_W-1:0] issued_line_i,
    output pf_verdict_e       verdict_o,
    output logic [ADDR_W-1:0] line_o
);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] LA_MULT   = ADDR_W'(LOOKAHEAD);
    localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

    logic [ADDR_W-1:0] acc_line;
    logic [ADDR_W-1:0] target;
    logic              same_page;
    logic              same_line;

    always_comb begin
        acc_line  = {cur_addr_i[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
        target    = conf_i ? (cur_addr_i + stride_i * LA_MULT)   // R3
                           : (acc_line + LINE_STEP);              // R2
        line_o    = {target[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};    // R5
        same_page = (target[ADDR_W-1:PAGE_W] == cur_addr_i[ADDR_W-1:PAGE_W]);
        same_line = (target[ADDR_W-1:LINE_W] == cur_addr_i[ADDR_W-1:LINE_W]);
        if (!same_page)                                  verdict_o = VERDICT_OFF_PAGE; // R6
        else if (same_line)                              verdict_o = VERDICT_OWN_LINE; // R7
        else if (issued_valid_i && line_o == issued_line_i) verdict_o = VERDICT_REPEAT; // R8
        else                                             verdict_o = VERDICT_ISSUE;
    end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int LOOKAHEAD  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output logic              pf_valid_o,
    input  logic              pf_ready_i,
    output logic [ADDR_W-1:0] pf_addr_o
);
    typedef struct packed {
        logic              have_hist;
        logic [ADDR_W-1:0] last_addr;
        logic [ADDR_W-1:0] stride;
        logic              conf;
        logic              issued_valid;  // pf_addr holds the last issued line
        logic              pend;
        logic [ADDR_W-1:0] pf_addr;
    } pf_state_t;

    pf_state_t         st_d, st_q;
    logic [ADDR_W-1:0] stride_nx;
    logic              conf_nx;
    pf_verdict_e       verdict;
    logic [ADDR_W-1:0] cand_line;

    stride_learn #(.ADDR_W(ADDR_W)) u_learn (
        .have_hist_i (st_q.have_hist),
        .last_addr_i (st_q.last_addr),
        .cur_addr_i  (acc_addr_i),
        .stride_i    (st_q.stride),
        .conf_i      (st_q.conf),
        .stride_o    (stride_nx),
        .conf_o      (conf_nx)
    );

    pf_target_gen #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .LOOKAHEAD  (LOOKAHEAD)
    ) u_target (
        .cur_addr_i     (acc_addr_i),
        .conf_i         (conf_nx),
        .stride_i       (stride_nx),
        .issued_valid_i (st_q.issued_valid),
        .issued_line_i  (st_q.pf_addr),
        .verdict_o      (verdict),
        .line_o         (cand_line)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.pend && pf_ready_i) begin
            st_d.pend = 1'b0;                          // R11
        end
        if (acc_valid_i) begin
            st_d.have_hist = 1'b1;
            st_d.last_addr = acc_addr_i;
            st_d.stride    = stride_nx;
            st_d.conf      = conf_nx;
            if (verdict == VERDICT_ISSUE) begin
                st_d.pend         = 1'b1;              // R10: replaces a stale one
                st_d.pf_addr      = cand_line;
                st_d.issued_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;                                // R1
        end else begin
            st_q <= st_d;
        end
    end

    assign pf_valid_o = st_q.pend;
    assign pf_addr_o  = st_q.pf_addr;
endmodule

// File: rtl/stride_pf_checker.sv
module stride_pf_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid_i,
    input logic [ADDR_W-1:0] acc_addr_i,
    input logic              pf_valid_o,
    input logic              pf_ready_i,
    input logic [ADDR_W-1:0] pf_addr_o
);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> !pf_valid_o);

    assert_rise_needs_access_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_valid_o) |-> $past(acc_valid_i));

    assert_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        pf_valid_o |-> (pf_addr_o[LINE_W-1:0] == '0));

    assert_in_page_R6: assert property (@(posedge clk) disable iff (rst)
        (pf_valid_o && $past(acc_valid_i) && (pf_addr_o != $past(pf_addr_o)))
        |-> (pf_addr_o[ADDR_W-1:PAGE_W] == $past(acc_addr_i[ADDR_W-1:PAGE_W])));

    assert_not_own_line_R7: assert property (@(posedge clk) disable iff (rst)
        (pf_valid_o && $past(acc_valid_i) && (pf_addr_o != $past(pf_addr_o)))
        |-> (pf_addr_o[ADDR_W-1:LINE_W] != $past(acc_addr_i[ADDR_W-1:LINE_W])));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pf_valid_o && !pf_ready_i && !acc_valid_i) |=> (pf_valid_o && $stable(pf_addr_o)));

    assert_retire_R11: assert property (@(posedge clk) disable iff (rst)
        (pf_valid_o && pf_ready_i && !acc_valid_i) |=> !pf_valid_o);
endmodule

bind stride_prefetcher stride_pf_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid_i (acc_valid_i),
    .acc_addr_i  (acc_addr_i),
    .pf_valid_o  (pf_valid_o),
    .pf_ready_i  (pf_ready_i),
    .pf_addr_o   (pf_addr_o)
);

// File: tb/stride_prefetcher_tb.sv
module stride_prefetcher_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        pf_ready = 1'b1;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";

    // behavioural reference state
    bit        m_have, m_conf, m_iv, m_pv;
    bit [31:0] m_last, m_stride, m_pa;

    always #5 clk = ~clk;

    stride_prefetcher u_dut (
        .clk         (clk),
        .rst         (rst),
        .acc_valid_i (acc_valid),
        .acc_addr_i  (acc_addr),
        .pf_valid_o  (pf_valid),
        .pf_ready_i  (pf_ready),
        .pf_addr_o   (pf_addr)
    );

    always @(posedge clk) begin
        bit [31:0] d, tgt, tl, al;
        bit        fresh;
        if (rst) begin
            m_have = 0; m_conf = 0; m_iv = 0; m_pv = 0;
            m_last = 0; m_stride = 0; m_pa = 0;
        end else begin
            fresh = 0;
            if (acc_valid) begin
                if (m_have) begin
                    d = acc_addr - m_last;
                    if (d != 0 && d == m_stride) m_conf = 1;
                    else begin m_conf = 0; m_stride = d; end
                end
                al  = acc_addr & 32'hFFFF_FFC0;
                tgt = m_conf ? acc_addr + 4 * m_stride : al + 64;
                tl  = tgt & 32'hFFFF_FFC0;
                m_have = 1; m_last = acc_addr;
                if ((tgt >> 12) == (acc_addr >> 12) && tl != al && !(m_iv && tl == m_pa)) begin
                    fresh = 1; m_pa = tl; m_iv = 1;
                end
            end
            if (fresh) m_pv = 1;
            else if (m_pv && pf_ready) m_pv = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare with the reference model every cycle
    always @(negedge clk) begin
        if (!rst) begin
            check(pf_valid == m_pv, tag, "valid vs model", 32'(pf_valid), 32'(m_pv));
            if (m_pv) check(pf_addr == m_pa, tag, "addr vs model", pf_addr, m_pa);
        end
    end

    task automatic expect_pf(input bit v, input logic [31:0] a, input string req);
        check(pf_valid == v, req, "valid", 32'(pf_valid), 32'(v));
        if (v) check(pf_addr == a, req, "addr", pf_addr, a);
    endtask

    task automatic access(input logic [31:0] a, input bit r);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; pf_ready = r;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic idle(input bit r);
        @(negedge clk);
        acc_valid = 1'b0; pf_ready = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog run hung actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        expect_pf(0, 0, "R1");

        // upward stride 0x200
        tag = "R2"; access(32'h1000, 1); expect_pf(1, 32'h1040, "R1");
        access(32'h1200, 1);             expect_pf(1, 32'h1240, "R2");
        tag = "R3"; access(32'h1400, 1); expect_pf(1, 32'h1C00, "R3");
        access(32'h1600, 1);             expect_pf(1, 32'h1E00, "R5");
        tag = "R6"; access(32'h1800, 1); expect_pf(0, 0, "R6");
        tag = "R4"; access(32'h1810, 1); expect_pf(1, 32'h1840, "R4");

        // tiny stride: duplicate and own-line suppression
        tag = "R8"; access(32'h3000, 1); expect_pf(1, 32'h3040, "R2");
        access(32'h3001, 1);             expect_pf(0, 0, "R8");
        tag = "R7"; access(32'h3002, 1); expect_pf(0, 0, "R7");
        access(32'h3003, 1);             expect_pf(0, 0, "R7");

        // downward stride -0x100 until the page edge
        tag = "R9"; access(32'h5F00, 1); expect_pf(1, 32'h5F40, "R2");
        access(32'h5E00, 1);             expect_pf(1, 32'h5E40, "R9");
        access(32'h5D00, 1);             expect_pf(1, 32'h5900, "R9");
        for (int i = 1; i <= 9; i++) access(32'h5D00 - 32'(i) * 32'h100, 1);
        expect_pf(1, 32'h5000, "R9");
        tag = "R6"; access(32'h5300, 1); expect_pf(0, 0, "R6");

        // zero delta breaks confirmation
        tag = "R4"; access(32'h7000, 1); access(32'h7040, 1);
        access(32'h7080, 1);             expect_pf(1, 32'h7180, "R3");
        access(32'h7080, 1);             expect_pf(1, 32'h70C0, "R4");
        access(32'h70C0, 1);             expect_pf(1, 32'h7100, "R4");
        access(32'h7100, 1);             expect_pf(1, 32'h7200, "R3");
        tag = "R11"; idle(1);            expect_pf(0, 0, "R11");

        // stalled port
        tag = "R10"; access(32'h8000, 0); expect_pf(1, 32'h8040, "R10");
        idle(0); idle(0);                 expect_pf(1, 32'h8040, "R10");
        access(32'h8100, 0);              expect_pf(1, 32'h8140, "R10");
        access(32'h8200, 0);              expect_pf(1, 32'h8600, "R10");
        idle(0); idle(0);                 expect_pf(1, 32'h8600, "R10");
        access(32'h8280, 0);              expect_pf(1, 32'h82C0, "R10");
        // handshake and new request in the same cycle
        tag = "R11"; access(32'h8300, 1); expect_pf(1, 32'h8500, "R11");
        idle(1);                          expect_pf(0, 0, "R11");

        // reset mid-stream clears history
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        tag = "R1"; expect_pf(0, 0, "R1");
        access(32'h9200, 1);              expect_pf(1, 32'h9240, "R1");

        idle(1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule